// File: doc/BRIEF.md
# Serial Command Frame and Lock Checker

This block sits beside the serial slave port of a gate-driver control chip and watches two things: the raw serial lines (chip select, serial clock and data in) and the stream of commands that the decoder produces from them. From the raw lines it judges whether each frame carried a whole number of bytes. It also judges whether the host disturbed the lines while a deadtime calibration measurement was running. From the command stream it judges whether each command is legal, given a sticky configuration lock.

The raw lines come from another clock domain. Each passes through a synchronizer chain before any edge is detected. A frame starts when the synchronized chip select goes low and is judged when it returns high. Each command handed over by the decoder gets exactly one outcome on the following cycle: either an execute strobe or a write-error pulse. A rejected command is never executed. Both error outputs are single-cycle pulses meant for the latched status register, which lives outside this block.

Top module: `spi_frame_guard`

## Requirements
- R1: After reset, `frame_err`, `write_err`, `cmd_exec` and `locked` are all 0.
- R2: A frame (synchronized chip select low, then high) that carries 8 or 16 rising serial clock edges produces no `frame_err` pulse.
- R3: A frame whose count of rising serial clock edges is not a multiple of 8 (for example 5 or 9) produces one `frame_err` pulse after chip select returns high.
- R4: A frame with no serial clock edges at all produces one `frame_err` pulse.
- R5: While `cal_active` is 1, every change of the synchronized serial clock or data line produces a `frame_err` pulse. The same changes with `cal_active` at 0 and chip select high produce none.
- R6: A command with `cmd_op` = 7 (undefined code) gives a `write_err` pulse on the next cycle and no `cmd_exec`.
- R7: While `locked` is 1, commands with code 1 (mask group A write), 2 (mask group B write), 3 (mode write) or 6 (deadtime command) give `write_err` on the next cycle and are not executed. Codes 0 (status read), 4 (clear group A) and 5 (clear group B) still execute.
- R8: An accepted mode write (code 3) with `cmd_lock` = 1 sets `locked` one cycle after the command. `locked` then stays 1 until reset.
- R9: Every cycle with `cmd_valid` = 1 is followed by exactly one of `cmd_exec` and `write_err`. A cycle without `cmd_valid` is followed by neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_in | input | 1 | Raw chip select, active low, asynchronous |
| sck_in | input | 1 | Raw serial clock, asynchronous |
| sdi_in | input | 1 | Raw serial data in, asynchronous |
| cal_active | input | 1 | Deadtime calibration measurement in progress (clk domain) |
| cmd_valid | input | 1 | Decoded command present this cycle |
| cmd_op | input | 3 | Decoded command code, values as in R6 and R7 |
| cmd_lock | input | 1 | Lock field of a mode write command |
| frame_err | output | 1 | Framing error pulse |
| write_err | output | 1 | Write error pulse |
| cmd_exec | output | 1 | Command accepted for execution |
| locked | output | 1 | Configuration lock state |

## Verification
The assertions cover only the command side. They assume that `cmd_valid`, `cmd_op` and `cmd_lock` are synchronous to `clk` and valid whenever `cmd_valid` is high. They make no assumption about how commands are spaced, so back-to-back commands are allowed. The framing checks depend on every serial line level being held for at least two clock periods, so that the synchronizer catches each level. The stimulus holds each level for three or four periods. It never moves chip select and serial clock in the same cycle, and it raises `cal_active` a few cycles before any toggle it expects to be flagged.

// File: rtl/spi_guard_pkg.sv
package spi_guard_pkg;

    typedef enum logic [2:0] {
        OP_STATUS   = 3'd0,
        OP_MASK_A   = 3'd1,
        OP_MASK_B   = 3'd2,
        OP_MODE     = 3'd3,
        OP_CLR_A    = 3'd4,
        OP_CLR_B    = 3'd5,
        OP_DEADTIME = 3'd6,
        OP_UNUSED   = 3'd7
    } cmd_op_e;

    // Codes that become illegal once the configuration is locked
    function automatic logic op_lockable(input logic [2:0] op);
        return (op == OP_MASK_A) || (op == OP_MASK_B) ||
               (op == OP_MODE)   || (op == OP_DEADTIME);
    endfunction

    function automatic logic op_defined(input logic [2:0] op);
        return op != OP_UNUSED;
    endfunction

    typedef struct packed {
        logic locked;
        logic werr;
        logic exec;
    } gate_st_t;

endpackage

// File: rtl/spi_line_sync.sv
module spi_line_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/spi_frame_check.sv
module spi_frame_check #(
    parameter int CNT_W = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_s,
    input  logic sck_s,
    input  logic sdi_s,
    input  logic cal_active,
    output logic frame_err
);
    typedef struct packed {
        logic             cs_p;
        logic             sck_p;
        logic             sdi_p;
        logic [CNT_W-1:0] cnt;
        logic             seen;
        logic             err;
    } frm_st_t;

    frm_st_t st_d, st_q;
    logic cs_fall, cs_rise, sck_rise, line_move;

    always_comb begin
        cs_fall   = st_q.cs_p & ~cs_n_s;
        cs_rise   = ~st_q.cs_p & cs_n_s;
        sck_rise  = ~st_q.sck_p & sck_s;
        line_move = (st_q.sck_p ^ sck_s) | (st_q.sdi_p ^ sdi_s);

        st_d       = st_q;
        st_d.cs_p  = cs_n_s;
        st_d.sck_p = sck_s;
        st_d.sdi_p = sdi_s;
        st_d.err   = 1'b0;

        if (cs_fall) begin
            st_d.cnt  = '0;
            st_d.seen = 1'b0;
        end else if (sck_rise && !cs_n_s) begin
            st_d.cnt  = st_q.cnt + 1'b1;
            st_d.seen = 1'b1;
        end

        if (cs_rise && ((st_q.cnt != '0) || !st_q.seen))
            st_d.err = 1'b1;
        if (cal_active && line_move)
            st_d.err = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.cs_p <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign frame_err = st_q.err;
endmodule

// File: rtl/cmd_lock_gate.sv
module cmd_lock_gate
    import spi_guard_pkg::*;
#(
    parameter int OP_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    input  logic [OP_W-1:0] cmd_op,
    input  logic            cmd_lock,
    output logic            write_err,
    output logic            cmd_exec,
    output logic            locked
);
    gate_st_t st_d, st_q;
    logic     illegal;

    always_comb begin
        illegal = !op_defined(cmd_op) || (st_q.locked && op_lockable(cmd_op));

        st_d      = st_q;
        st_d.werr = cmd_valid & illegal;
        st_d.exec = cmd_valid & ~illegal;
        if (cmd_valid && !illegal && (cmd_op == OP_MODE) && cmd_lock)
            st_d.locked = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign write_err = st_q.werr;
    assign cmd_exec  = st_q.exec;
    assign locked    = st_q.locked;
endmodule

// File: rtl/spi_frame_guard.sv
module spi_frame_guard #(
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 3,
    parameter int OP_W        = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cs_n_in,
    input  logic            sck_in,
    input  logic            sdi_in,
    input  logic            cal_active,
    input  logic            cmd_valid,
    input  logic [OP_W-1:0] cmd_op,
    input  logic            cmd_lock,
    output logic            frame_err,
    output logic            write_err,
    output logic            cmd_exec,
    output logic            locked
);
    localparam int         N_LINES   = 3;
    localparam logic [2:0] LINE_IDLE = 3'b001;  // bit0 chip select idles high

    logic [N_LINES-1:0] raw, synced;
    assign raw = {sdi_in, sck_in, cs_n_in};

    for (genvar i = 0; i < N_LINES; i++) begin : g_sync
        spi_line_sync #(
            .STAGES (SYNC_STAGES),
            .RST_VAL(LINE_IDLE[i])
        ) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .d    (raw[i]),
            .q    (synced[i])
        );
    end

    spi_frame_check #(.CNT_W(CNT_W)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n_s    (synced[0]),
        .sck_s     (synced[1]),
        .sdi_s     (synced[2]),
        .cal_active(cal_active),
        .frame_err (frame_err)
    );

    cmd_lock_gate #(.OP_W(OP_W)) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_valid(cmd_valid),
        .cmd_op   (cmd_op),
        .cmd_lock (cmd_lock),
        .write_err(write_err),
        .cmd_exec (cmd_exec),
        .locked   (locked)
    );
endmodule

// File: rtl/spi_frame_guard_chk.sv
module spi_frame_guard_chk #(
    parameter int OP_W = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cmd_valid,
    input logic [OP_W-1:0] cmd_op,
    input logic            cmd_lock,
    input logic            write_err,
    input logic            cmd_exec,
    input logic            locked
);
    AST_UNDEF_OP_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd7) |=> (write_err && !cmd_exec)); // R6

    AST_LOCKED_PROTECT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && locked && (cmd_op == 3'd1 || cmd_op == 3'd2 ||
         cmd_op == 3'd3 || cmd_op == 3'd6)) |=> (write_err && !cmd_exec)); // R7

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked); // R8

    AST_LOCK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(cmd_valid && cmd_op == 3'd3 && cmd_lock)); // R8

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> (write_err ^ cmd_exec)); // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> (!write_err && !cmd_exec)); // R9
endmodule

bind spi_frame_guard spi_frame_guard_chk #(.OP_W(OP_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_valid(cmd_valid),
    .cmd_op   (cmd_op),
    .cmd_lock (cmd_lock),
    .write_err(write_err),
    .cmd_exec (cmd_exec),
    .locked   (locked)
);

// File: tb/spi_frame_guard_tb.sv
module spi_frame_guard_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n_in = 1'b1, sck_in = 1'b0, sdi_in = 1'b0;
    logic       cal_active = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_op = '0;
    logic       cmd_lock = 1'b0;
    logic       frame_err, write_err, cmd_exec, locked;

    int    checks = 0, failures = 0;
    string cur_req = "R1";
    int    ferr_seen = 0;
    bit    done = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    spi_frame_guard u_dut (.*);

    // Behavioural reference model
    bit q_cs[$], q_sck[$], q_sdi[$];
    int m_bits = 0;
    bit m_lock = 0;
    bit e_ferr = 0, e_werr = 0, e_exec = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_cs = {1, 1, 1, 1}; q_sck = {0, 0, 0, 0}; q_sdi = {0, 0, 0, 0};
            m_bits = 0; m_lock = 0; e_ferr = 0; e_werr = 0; e_exec = 0;
        end else begin
            bit cs_now, cs_old, ck_now, ck_old, di_now, di_old, bad_op;
            q_cs.push_back(cs_n_in); q_sck.push_back(sck_in); q_sdi.push_back(sdi_in);
            if (q_cs.size() > 8) begin
                void'(q_cs.pop_front()); void'(q_sck.pop_front()); void'(q_sdi.pop_front());
            end
            cs_now = q_cs[q_cs.size()-3];  cs_old = q_cs[q_cs.size()-4];
            ck_now = q_sck[q_sck.size()-3]; ck_old = q_sck[q_sck.size()-4];
            di_now = q_sdi[q_sdi.size()-3]; di_old = q_sdi[q_sdi.size()-4];
            e_ferr = 0;
            if (!cs_old && cs_now && (m_bits == 0 || m_bits % 8 != 0)) e_ferr = 1;
            if (cal_active && (ck_now != ck_old || di_now != di_old)) e_ferr = 1;
            if (cs_old && !cs_now) m_bits = 0;
            else if (!ck_old && ck_now && !cs_now) m_bits++;
            bad_op = (cmd_op == 7) ||
                     (m_lock && (cmd_op == 1 || cmd_op == 2 || cmd_op == 3 || cmd_op == 6));
            e_werr = cmd_valid && bad_op;
            e_exec = cmd_valid && !bad_op;
            if (e_exec && cmd_op == 3 && cmd_lock) m_lock = 1;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (frame_err) ferr_seen++;
            if (frame_err !== e_ferr || write_err !== e_werr ||
                cmd_exec !== e_exec || locked !== m_lock) begin
                chk(cur_req, "model {ferr,werr,exec,lock}",
                    {frame_err, write_err, cmd_exec, locked},
                    {e_ferr, e_werr, e_exec, m_lock});
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic frame(input int nbits);
        cs_n_in = 1'b0; idle(4);
        for (int b = 0; b < nbits; b++) begin
            sdi_in = b[0] ^ b[2];
            sck_in = 1'b1; idle(3);
            sck_in = 1'b0; idle(3);
        end
        idle(1); cs_n_in = 1'b1; idle(8);
    endtask

    task automatic frame_case(input string req, input int nbits, input int exp);
        cur_req = req;
        ferr_seen = 0;
        frame(nbits);
        chk(req, $sformatf("frame_err pulses for %0d bits", nbits), ferr_seen, exp);
    endtask

    // drive one command, then observe its outcome on the next cycle
    task automatic send(input string req, input int op, input bit lk,
                        input bit exp_exec, input bit exp_werr);
        cur_req = req;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op[2:0]; cmd_lock = lk;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(req, $sformatf("cmd_exec op %0d", op), cmd_exec, exp_exec);
        chk(req, $sformatf("write_err op %0d", op), write_err, exp_werr);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++; checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "frame_err", frame_err, 0);
        chk("R1", "write_err", write_err, 0);
        chk("R1", "cmd_exec", cmd_exec, 0);
        chk("R1", "locked", locked, 0);
        idle(4);

        frame_case("R2", 8, 0);
        frame_case("R2", 16, 0);
        frame_case("R3", 5, 1);
        frame_case("R3", 9, 1);
        frame_case("R4", 0, 1);

        // R5: toggles during calibration window
        cur_req = "R5"; ferr_seen = 0;
        cal_active = 1'b1; idle(2);
        sck_in = 1'b1; idle(4);
        sck_in = 1'b0; idle(4);
        sdi_in = ~sdi_in; idle(6);
        cal_active = 1'b0; idle(2);
        chk("R5", "frame_err pulses in calibration", ferr_seen, 3);
        ferr_seen = 0;
        sck_in = 1'b1; idle(4);
        sck_in = 1'b0; idle(4);
        sdi_in = ~sdi_in; idle(6);
        chk("R5", "frame_err pulses outside calibration", ferr_seen, 0);

        // unlocked: all defined codes execute
        for (int op = 0; op < 7; op++) send("R9", op, 1'b0, 1'b1, 1'b0);
        send("R6", 7, 1'b0, 1'b0, 1'b1);
        send("R8", 3, 1'b1, 1'b1, 1'b0);
        chk("R8", "locked after lock write", locked, 1);

        // locked: protected codes rejected, others still execute
        send("R7", 1, 1'b0, 1'b0, 1'b1);
        send("R7", 2, 1'b0, 1'b0, 1'b1);
        send("R7", 3, 1'b0, 1'b0, 1'b1);
        send("R7", 6, 1'b0, 1'b0, 1'b1);
        send("R7", 0, 1'b0, 1'b1, 1'b0);
        send("R7", 4, 1'b0, 1'b1, 1'b0);
        send("R7", 5, 1'b0, 1'b1, 1'b0);
        send("R6", 7, 1'b0, 1'b0, 1'b1);
        idle(20);
        chk("R8", "lock held", locked, 1);

        // back-to-back commands, one outcome each
        cur_req = "R9";
        @(negedge clk); cmd_valid = 1'b1; cmd_op = 3'd0;
        @(negedge clk); cmd_op = 3'd7;
        chk("R9", "exec of first", cmd_exec, 1);
        @(negedge clk); cmd_valid = 1'b0;
        chk("R9", "werr of second", write_err, 1);
        chk("R9", "no exec with werr", cmd_exec, 0);
        @(negedge clk);
        chk("R9", "quiet after idle", {write_err, cmd_exec}, 0);

        // reset clears lock
        cur_req = "R1";
        rst_n = 1'b0; idle(2); rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "locked after reset", locked, 0);
        send("R8", 1, 1'b0, 1'b1, 1'b0);

        idle(4);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule